// File: doc/BRIEF.md
# Sequential Restoring Divider with Overflow Check

This block divides an 8-bit unsigned dividend by a 4-bit unsigned divisor over several clock cycles. The result is a 4-bit quotient and a 4-bit remainder. A 9-bit working register holds the dividend. A 5-bit trial subtracter, built as a ripple chain of full subtractors, compares the upper five bits of that register with the zero-extended divisor. The inverted final borrow is the "can subtract" signal.

A controller sequences the operation through six states:

- `ST_IDLE` waits for `start` and moves to `ST_LOAD`.
- `ST_LOAD` captures both operands and moves to `ST_CHECK`.
- `ST_CHECK` performs the overflow test. If the test fails, it takes the abort path back to `ST_IDLE`. Otherwise it moves to `ST_SHIFT`.
- `ST_SHIFT` shifts the working register left by one bit and moves to `ST_SUB`.
- `ST_SUB` is the conditional-subtract step. It writes the new quotient bit into bit 0. It returns to `ST_SHIFT` until four rounds are done, then moves to `ST_DONE`.
- `ST_DONE` raises `done` for one cycle and returns to `ST_IDLE`.

The overflow test catches any quotient that would not fit in four bits, and division by zero, before any iteration runs.

After a good division, bits 3..0 of the working register form the quotient and bits 7..4 form the remainder. Both stay on the outputs until the next operation loads new operands.

Top module: `seq_divider`

## Requirements
- R1: While reset is low and after it is released, with no start seen, `quotient`, `remainder`, `done` and `ovf` are all 0.
- R2: `start` sampled high in `ST_IDLE` at clock edge E launches a divide. The operands on `dividend` and `divisor` are captured at edge E+1.
- R3: If `dividend[7:4]` >= `divisor` (this includes `divisor` = 0), `ovf` is 1 from edge E+2 until the next load. `done` is never raised for that operation.
- R4: On overflow the working register is left as loaded. `quotient` equals `dividend[3:0]` and `remainder` equals `dividend[7:4]`.
- R5: A divide without overflow raises `done` for exactly one cycle, during the cycle that follows edge E+10.
- R6: When `done` is high, `quotient` equals `dividend / divisor` and `remainder` equals `dividend % divisor`. Both hold their values until the next start.
- R7: `ovf` is cleared at the load edge (E+1) of every new operation.
- R8: `start` is ignored while an operation is in progress. The result and the `done` timing are unchanged.
- R9: When `done` is high, `remainder` is less than the captured divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a divide when idle |
| dividend | input | 8 | Unsigned dividend, captured in the load state |
| divisor | input | 4 | Unsigned divisor, captured in the load state |
| quotient | output | 4 | Quotient, bits 3..0 of the working register |
| remainder | output | 4 | Remainder, bits 7..4 of the working register |
| done | output | 1 | One-cycle pulse when a valid result is ready |
| ovf | output | 1 | Overflow or divide-by-zero flag |

## Verification
Counting the edge that samples `start` as E, `ovf` is cleared at E+1 and set at E+2, and `done` appears after E+10. The bench drives inputs on falling edges and counts falling edges from the start pulse. It checks `ovf` at the second and third falling edges, checks that `done` stays low on every falling edge before the eleventh, and checks `done` and the result at the eleventh. At the twelfth falling edge it confirms that `done` has dropped and that the result is still held. A stray `start` pulse is injected in the middle of some operations, and the same windows must still hold.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOAD  = 3'd1,
        ST_CHECK = 3'd2,
        ST_SHIFT = 3'd3,
        ST_SUB   = 3'd4,
        ST_DONE  = 3'd5
    } div_state_e;

endpackage

// File: rtl/div_full_sub.sv
module div_full_sub (
    input  logic a,
    input  logic b,
    input  logic bin,
    output logic d,
    output logic bout
);
    always_comb begin
        d    = a ^ b ^ bin;
        bout = (~a & b) | (~(a ^ b) & bin);
    end
endmodule

// File: rtl/div_sub_unit.sv
module div_sub_unit #(
    parameter int W = 5
) (
    input  logic [W-1:0] minuend,
    input  logic [W-1:0] subtrahend,
    output logic [W-1:0] diff,
    output logic         can_sub
);
    logic [W:0] borrow;

    assign borrow[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_stage
        div_full_sub u_fs (
            .a    (minuend[i]),
            .b    (subtrahend[i]),
            .bin  (borrow[i]),
            .d    (diff[i]),
            .bout (borrow[i+1])
        );
    end

    // No final borrow means the minuend is not less than the subtrahend
    assign can_sub = ~borrow[W];
endmodule

// File: rtl/div_datapath.sv
module div_datapath #(
    parameter int QW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_en,
    input  logic            shift_en,
    input  logic            sub_en,
    input  logic [2*QW-1:0] dividend,
    input  logic [QW-1:0]   divisor,
    output logic [2*QW:0]   x_q,
    output logic [QW-1:0]   y_q,
    output logic            can_sub
);
    localparam int XW = 2*QW + 1;
    localparam int UW = QW + 1;

    logic [UW-1:0] upper;
    logic [UW-1:0] y_ext;
    logic [UW-1:0] diff;

    assign upper = x_q[XW-1:QW];
    assign y_ext = {1'b0, y_q};

    div_sub_unit #(.W(UW)) u_sub (
        .minuend    (upper),
        .subtrahend (y_ext),
        .diff       (diff),
        .can_sub    (can_sub)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q <= '0;
            y_q <= '0;
        end else if (load_en) begin
            x_q <= {1'b0, dividend};
            y_q <= divisor;
        end else if (shift_en) begin
            x_q <= {x_q[XW-2:0], 1'b0};
        end else if (sub_en) begin
            if (can_sub) begin
                x_q <= {diff, x_q[QW-1:1], 1'b1};
            end else begin
                x_q <= {x_q[XW-1:1], 1'b0};
            end
        end
    end
endmodule

// File: rtl/div_ctrl.sv
module div_ctrl
    import div_pkg::*;
#(
    parameter int QW = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       can_sub,
    output div_state_e state,
    output logic       load_en,
    output logic       shift_en,
    output logic       sub_en,
    output logic       done,
    output logic       ovf
);
    localparam int CW = (QW > 1) ? $clog2(QW) : 1;
    localparam logic [CW-1:0] LAST = CW'(QW - 1);

    div_state_e    state_n;
    logic [CW-1:0] cnt_q;
    logic          last_round;

    assign last_round = (cnt_q == LAST);

    // State register, round counter and overflow flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt_q <= '0;
            ovf   <= 1'b0;
        end else begin
            state <= state_n;
            if (state == ST_CHECK) begin
                cnt_q <= '0;
            end else if (state == ST_SUB) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (state == ST_LOAD) begin
                ovf <= 1'b0;
            end else if (state == ST_CHECK && can_sub) begin
                ovf <= 1'b1;
            end
        end
    end

    // Next-state selection
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (start) state_n = ST_LOAD;
            ST_LOAD:  state_n = ST_CHECK;
            ST_CHECK: state_n = can_sub ? ST_IDLE : ST_SHIFT;
            ST_SHIFT: state_n = ST_SUB;
            ST_SUB:   state_n = last_round ? ST_DONE : ST_SHIFT;
            ST_DONE:  state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        load_en  = 1'b0;
        shift_en = 1'b0;
        sub_en   = 1'b0;
        done     = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_LOAD:  load_en  = 1'b1;
            ST_CHECK: ;
            ST_SHIFT: shift_en = 1'b1;
            ST_SUB:   sub_en   = 1'b1;
            ST_DONE:  done     = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/seq_divider.sv
module seq_divider
    import div_pkg::*;
#(
    parameter int QW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2*QW-1:0] dividend,
    input  logic [QW-1:0]   divisor,
    output logic [QW-1:0]   quotient,
    output logic [QW-1:0]   remainder,
    output logic            done,
    output logic            ovf
);
    localparam int XW = 2*QW + 1;

    div_state_e    state;
    logic          load_en;
    logic          shift_en;
    logic          sub_en;
    logic          can_sub;
    logic [XW-1:0] x_q;
    logic [QW-1:0] y_q;

    div_ctrl #(.QW(QW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .can_sub  (can_sub),
        .state    (state),
        .load_en  (load_en),
        .shift_en (shift_en),
        .sub_en   (sub_en),
        .done     (done),
        .ovf      (ovf)
    );

    div_datapath #(.QW(QW)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .shift_en (shift_en),
        .sub_en   (sub_en),
        .dividend (dividend),
        .divisor  (divisor),
        .x_q      (x_q),
        .y_q      (y_q),
        .can_sub  (can_sub)
    );

    assign quotient  = x_q[QW-1:0];
    assign remainder = x_q[2*QW-1:QW];
endmodule

// File: rtl/div_checker.sv
module div_checker
    import div_pkg::*;
#(
    parameter int QW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          done,
    input logic          ovf,
    input logic [QW-1:0] quotient,
    input logic [QW-1:0] remainder,
    input logic [QW-1:0] y_q,
    input div_state_e    state
);
    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    ovf_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> !done);

    // R4
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> ($stable(quotient) && $stable(remainder)));

    // R9
    rem_below_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (remainder < y_q));

    // R8
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && start) |=> (state == ST_SUB));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> ($stable(quotient) && $stable(remainder)));
endmodule

bind seq_divider div_checker #(.QW(QW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .done      (done),
    .ovf       (ovf),
    .quotient  (quotient),
    .remainder (remainder),
    .y_q       (y_q),
    .state     (state)
);

// File: tb/tb_seq_divider.sv
`timescale 1ns/1ps
module tb_seq_divider;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       start;
    logic [7:0] dividend;
    logic [3:0] divisor;
    logic [3:0] quotient;
    logic [3:0] remainder;
    logic       done;
    logic       ovf;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int seed_init;

    always #2 clk = ~clk;

    seq_divider dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .dividend  (dividend),
        .divisor   (divisor),
        .quotient  (quotient),
        .remainder (remainder),
        .done      (done),
        .ovf       (ovf)
    );

    function automatic bit exp_ovf(input logic [7:0] a, input logic [3:0] b);
        return (b == 0) || ((int'(a) / int'(b)) > 15);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_div(input logic [7:0] a, input logic [3:0] b, input bit poke);
        bit eo;
        bit early;
        eo = exp_ovf(a, b);
        @(negedge clk);
        dividend = a; divisor = b; start = 1'b1;
        @(negedge clk);                           // after edge E
        start = 1'b0;
        chk("R2 done low after start", int'(done), 0);
        @(negedge clk);                           // after E+1
        chk("R7 ovf cleared at load", int'(ovf), 0);
        if (eo) begin
            @(negedge clk);                       // after E+2
            chk("R3 ovf raised", int'(ovf), 1);
            chk("R4 quotient held", int'(quotient), int'(a[3:0]));
            chk("R4 remainder held", int'(remainder), int'(a[7:4]));
            early = 1'b0;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (done) early = 1'b1;
            end
            chk("R3 no done on overflow", int'(early), 0);
            chk("R3 ovf stays set", int'(ovf), 1);
        end else begin
            early = 1'b0;
            for (int k = 3; k <= 10; k++) begin
                @(negedge clk);                   // after E+(k-1)
                if (poke && k == 4) begin
                    start = 1'b1; dividend = ~a; divisor = b + 4'd1;
                end
                if (poke && k == 5) begin
                    start = 1'b0; dividend = a; divisor = b;
                end
                if (done || ovf) early = 1'b1;
            end
            chk(poke ? "R8 no early done or ovf" : "R5 no early done or ovf", int'(early), 0);
            @(negedge clk);                       // after E+10
            chk("R5 done pulse", int'(done), 1);
            chk(poke ? "R8 quotient" : "R6 quotient", int'(quotient), int'(a) / int'(b));
            chk(poke ? "R8 remainder" : "R6 remainder", int'(remainder), int'(a) % int'(b));
            @(negedge clk);
            chk("R5 done one cycle", int'(done), 0);
            chk("R6 quotient held", int'(quotient), int'(a) / int'(b));
            chk("R6 remainder held", int'(remainder), int'(a) % int'(b));
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        seed_init = $urandom(32'h5EED);
        rst_n = 1'b0; start = 1'b0; dividend = '0; divisor = '0;
        repeat (3) @(negedge clk);
        chk("R1 quotient in reset", int'(quotient), 0);
        chk("R1 ovf in reset", int'(ovf), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 quotient", int'(quotient), 0);
        chk("R1 remainder", int'(remainder), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 ovf", int'(ovf), 0);

        // Directed corner cases
        run_div(8'd239, 4'd15, 1'b0);   // largest quotient that fits
        run_div(8'd240, 4'd15, 1'b0);   // quotient 16: overflow
        run_div(8'd100, 4'd7,  1'b0);   // follows overflow, ovf must clear
        run_div(8'd77,  4'd0,  1'b0);   // divide by zero
        run_div(8'd0,   4'd1,  1'b0);
        run_div(8'd15,  4'd1,  1'b0);
        run_div(8'd16,  4'd1,  1'b0);   // overflow at the boundary
        run_div(8'd7,   4'd8,  1'b0);   // quotient 0
        run_div(8'd255, 4'd15, 1'b0);
        run_div(8'd200, 4'd13, 1'b1);   // stray start mid-run

        // Random operands
        for (int i = 0; i < 150; i++) begin
            logic [7:0] ra;
            logic [3:0] rb;
            ra = 8'($urandom % 256);
            rb = 4'($urandom % 16);
            if (i % 3 == 0) ra[7:4] = 4'($urandom % (rb == 0 ? 1 : int'(rb)));
            run_div(ra, rb, (i % 7) == 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule